// File: doc/BRIEF.md
# Bus-Mapped 32-bit Adder

This block is an AXI4-Lite slave that puts a 32-bit adder behind five word registers. Software loads the two addends into read/write registers, then writes a control word with its launch bit set. One cycle after that write is committed, the block stores the 32-bit sum and the carry-out in read-only result registers and raises a done flag in the control word. The done flag stays up until software has fetched both the sum and the carry, in either order. A later launch replaces the earlier results and raises the flag again.

The bus side is a five-state machine. It accepts the write address and write data in any order, including in the same cycle. It commits the write in a cycle of its own and then holds the write response until the master takes it. A read captures its data when the address is accepted and holds it until the master takes it. Only single 32-bit accesses are supported. Every access receives an OKAY response, including accesses to addresses that decode to no register.

Top module: `axil_adder_regs`

## Requirements
- R1: After reset, every register reads as zero, no write response or read response is pending, and the address channels are ready.
- R2: Addend X (word index 0, byte address 0x00) and addend Y (index 1, 0x04) are read/write registers; each strobe bit `s_wstrb[k]` enables byte lane k of the written word.
- R3: In the control word (index 2, 0x08), writing 1 to bit 0 with `s_wstrb[0]` set launches an addition; bit 0 always reads back as 0, and a new launch overwrites previous results.
- R4: The sum register (index 3, 0x0C) holds (X + Y) mod 2^32, and bit 0 of the carry register (index 4, 0x10) holds the carry-out, with all other bits 0 (0xFFFFFFFF + 0xFFFFFFFF gives 0xFFFFFFFE, carry 1).
- R5: Bit 1 of the control word (done) sets when the results are stored; it clears only once the sum and the carry have both been read since that launch, in either order, and repeated reads of only one of them leave it set.
- R6: Bus writes to the sum register, the carry register, or the done bit leave their contents unchanged.
- R7: Address bits [1:0] are ignored in decoding; a read from a word index of 5 or above returns 0 with OKAY, and a write there is acknowledged with OKAY and discarded.
- R8: Write address and write data are accepted in either order or together; each write yields exactly one write response with OKAY (`s_bresp` = 2'b00), held until `s_bready`.
- R9: A read response keeps `s_rvalid` high and `s_rdata` stable until `s_rready`, always with `s_rresp` = OKAY.
- R10: The bus machine only visits IDLE, WRITE_WAIT, WRITE, WRITE_RESP and READ along their legal transitions; when a write and a read are offered together in IDLE, the write is served first.
- R11: A reset asserted during an access or after a computation clears every register and the done flag and returns the bus to idle, after which normal accesses work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |

## Verification
The bench uses the default parameters: a 32-bit data path and an 8-bit address. With these values, word indices 5 through 63 decode to no register, so the bench can test both unused words just past the map (0x14) and words at the far end of the space (0xFC). The 32-bit width makes the full-scale addition reachable, so the carry-out and the wrap of the sum can be checked directly. The four strobe lanes allow partial writes to single bytes of an addend.

// File: rtl/axadd_pkg.sv
package axadd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WRITE_WAIT = 3'd1,
    ST_WRITE      = 3'd2,
    ST_WRITE_RESP = 3'd3,
    ST_READ       = 3'd4
  } bus_state_t;

  localparam int REG_OPA   = 0;
  localparam int REG_OPB   = 1;
  localparam int REG_CTRL  = 2;
  localparam int REG_SUM   = 3;
  localparam int REG_CARRY = 4;
  localparam int NUM_REGS  = 5;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_DONE_BIT = 1;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axadd_rst_sync.sv
module axadd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/axadd_bus_fsm.sv
module axadd_bus_fsm
  import axadd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output bus_state_t        state
);

  bus_state_t        state_q, state_n;
  logic              aw_got_q, aw_got_n;
  logic              w_got_q, w_got_n;
  logic [ADDR_W-1:0] awaddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [STRB_W-1:0] wstrb_q;
  logic [DATA_W-1:0] rdata_q;
  logic              aw_hs, w_hs, ar_hs;

  // channel readiness follows the state and what has been captured so far
  always_comb begin
    s_awready = 1'b0;
    s_wready  = 1'b0;
    s_arready = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        s_awready = 1'b1;
        s_wready  = 1'b1;
        s_arready = !s_awvalid && !s_wvalid;
      end
      ST_WRITE_WAIT: begin
        s_awready = !aw_got_q;
        s_wready  = !w_got_q;
      end
      default: ;
    endcase
  end

  assign aw_hs = s_awvalid && s_awready;
  assign w_hs  = s_wvalid && s_wready;
  assign ar_hs = s_arvalid && s_arready;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (aw_hs && w_hs)      state_n = ST_WRITE;
        else if (aw_hs || w_hs) state_n = ST_WRITE_WAIT;
        else if (ar_hs)         state_n = ST_READ;
      end
      ST_WRITE_WAIT: begin
        if ((aw_got_q || aw_hs) && (w_got_q || w_hs)) state_n = ST_WRITE;
      end
      ST_WRITE:      state_n = ST_WRITE_RESP;
      ST_WRITE_RESP: if (s_bready) state_n = ST_IDLE;
      ST_READ:       if (s_rready) state_n = ST_IDLE;
      default:       state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    aw_got_n = aw_got_q;
    w_got_n  = w_got_q;
    if (state_q == ST_WRITE) begin
      aw_got_n = 1'b0;
      w_got_n  = 1'b0;
    end else begin
      if (aw_hs) aw_got_n = 1'b1;
      if (w_hs)  w_got_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      aw_got_q <= 1'b0;
      w_got_q  <= 1'b0;
    end else begin
      state_q  <= state_n;
      aw_got_q <= aw_got_n;
      w_got_q  <= w_got_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awaddr_q <= '0;
    end else if (aw_hs) begin
      awaddr_q <= s_awaddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      wstrb_q <= '0;
    end else if (w_hs) begin
      wdata_q <= s_wdata;
      wstrb_q <= s_wstrb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (ar_hs) begin
      rdata_q <= rd_data;
    end
  end

  assign wr_en    = (state_q == ST_WRITE);
  assign wr_addr  = awaddr_q;
  assign wr_data  = wdata_q;
  assign wr_strb  = wstrb_q;
  assign rd_en    = ar_hs;
  assign rd_addr  = s_araddr;
  assign s_bvalid = (state_q == ST_WRITE_RESP);
  assign s_rvalid = (state_q == ST_READ);
  assign s_rdata  = rdata_q;
  assign state    = state_q;

endmodule

// File: rtl/axadd_operands.sv
module axadd_operands
  import axadd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb
);

  logic a_sel, b_sel;

  assign a_sel = wr_en && (wr_idx == IDX_W'(REG_OPA));
  assign b_sel = wr_en && (wr_idx == IDX_W'(REG_OPB));

  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    logic [7:0] a_byte_q, b_byte_q;
    logic       a_ce, b_ce;

    assign a_ce = a_sel && wr_strb[g];
    assign b_ce = b_sel && wr_strb[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_byte_q <= '0;
      end else if (a_ce) begin
        a_byte_q <= wr_data[g*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_byte_q <= '0;
      end else if (b_ce) begin
        b_byte_q <= wr_data[g*8 +: 8];
      end
    end

    assign opa[g*8 +: 8] = a_byte_q;
    assign opb[g*8 +: 8] = b_byte_q;
  end

endmodule

// File: rtl/axadd_core.sv
module axadd_core
  import axadd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              go,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              done
);

  logic              go_q, go_n;
  logic [DATA_W-1:0] sum_q;
  logic              carry_q;
  logic              done_q, done_n;
  logic              seen_sum_q, seen_sum_n;
  logic              seen_cy_q, seen_cy_n;
  logic [DATA_W:0]   add_full;
  logic              rd_sum, rd_cy;

  // launch pulse: one cycle long, raised by the commit of a control write
  assign go_n = wr_en && (wr_idx == IDX_W'(REG_CTRL)) && wr_strb[0] &&
                wr_data[CTRL_GO_BIT];

  assign add_full = {1'b0, opa} + {1'b0, opb};

  assign rd_sum = rd_en && (rd_idx == IDX_W'(REG_SUM));
  assign rd_cy  = rd_en && (rd_idx == IDX_W'(REG_CARRY));

  always_comb begin
    seen_sum_n = seen_sum_q;
    seen_cy_n  = seen_cy_q;
    done_n     = done_q;
    if (go_q) begin
      seen_sum_n = 1'b0;
      seen_cy_n  = 1'b0;
      done_n     = 1'b1;
    end else begin
      if (rd_sum) seen_sum_n = 1'b1;
      if (rd_cy)  seen_cy_n  = 1'b1;
      if (seen_sum_n && seen_cy_n) done_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0;
    end else begin
      go_q <= go_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= 1'b0;
    end else if (go_q) begin
      sum_q   <= add_full[DATA_W-1:0];
      carry_q <= add_full[DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      seen_sum_q <= 1'b0;
      seen_cy_q  <= 1'b0;
    end else begin
      done_q     <= done_n;
      seen_sum_q <= seen_sum_n;
      seen_cy_q  <= seen_cy_n;
    end
  end

  assign go    = go_q;
  assign sum   = sum_q;
  assign carry = carry_q;
  assign done  = done_q;

endmodule

// File: rtl/axil_adder_regs.sv
module axil_adder_regs
  import axadd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int STRB_W = DATA_W / 8,
  localparam int IDX_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready
);

  logic              rst_n_sync;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] opa, opb, sum;
  logic              go, carry, done;
  bus_state_t        bus_state;

  axadd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  axadd_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .s_awaddr  (s_awaddr),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_wdata   (s_wdata),
    .s_wstrb   (s_wstrb),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_araddr  (s_araddr),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rdata   (s_rdata),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_strb   (wr_strb),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .state     (bus_state)
  );

  // word decode: the two lowest address bits never take part
  assign wr_idx = wr_addr[ADDR_W-1:2];
  assign rd_idx = rd_addr[ADDR_W-1:2];

  axadd_operands #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ops (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_strb (wr_strb),
    .opa     (opa),
    .opb     (opb)
  );

  axadd_core #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_strb (wr_strb),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .opa     (opa),
    .opb     (opb),
    .go      (go),
    .sum     (sum),
    .carry   (carry),
    .done    (done)
  );

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      IDX_W'(REG_OPA):   rd_data = opa;
      IDX_W'(REG_OPB):   rd_data = opb;
      IDX_W'(REG_CTRL): begin
        rd_data[CTRL_GO_BIT]   = go;
        rd_data[CTRL_DONE_BIT] = done;
      end
      IDX_W'(REG_SUM):   rd_data = sum;
      IDX_W'(REG_CARRY): rd_data[0] = carry;
      default:           rd_data = '0;
    endcase
  end

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;

endmodule

// File: rtl/axadd_checker.sv
module axadd_checker
  import axadd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input bus_state_t        state,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              go,
  input logic [DATA_W-1:0] sum,
  input logic              carry,
  input logic              done
);

  assert_state_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state inside {ST_IDLE, ST_WRITE_WAIT, ST_WRITE, ST_WRITE_RESP, ST_READ});

  assert_wait_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE_WAIT) |=> (state inside {ST_WRITE_WAIT, ST_WRITE}));

  assert_commit_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE) |=> (state == ST_WRITE_RESP));

  assert_resp_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE_RESP) |=> (state inside {ST_WRITE_RESP, ST_IDLE}));

  assert_read_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ) |=> (state inside {ST_READ, ST_IDLE}));

  assert_one_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bvalid && rvalid));

  assert_bvalid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);

  assert_bresp_okay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == RESP_OKAY));

  assert_rvalid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));

  assert_rresp_okay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rresp == RESP_OKAY));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(sum) && $stable(carry)));

  assert_done_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> done);

  assert_done_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(go));

endmodule

bind axil_adder_regs axadd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .state  (bus_state),
  .bvalid (s_bvalid),
  .bready (s_bready),
  .bresp  (s_bresp),
  .rvalid (s_rvalid),
  .rready (s_rready),
  .rdata  (s_rdata),
  .rresp  (s_rresp),
  .go     (go),
  .sum    (sum),
  .carry  (carry),
  .done   (done)
);

// File: tb/axil_adder_regs_test.sv
`timescale 1ns/1ps
module axil_adder_regs_test;

  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] s_awaddr = '0;
  logic          s_awvalid = 1'b0;
  logic          s_awready;
  logic [DW-1:0] s_wdata = '0;
  logic [3:0]    s_wstrb = '0;
  logic          s_wvalid = 1'b0;
  logic          s_wready;
  logic [1:0]    s_bresp;
  logic          s_bvalid;
  logic          s_bready = 1'b1;
  logic [AW-1:0] s_araddr = '0;
  logic          s_arvalid = 1'b0;
  logic          s_arready;
  logic [DW-1:0] s_rdata;
  logic [1:0]    s_rresp;
  logic          s_rvalid;
  logic          s_rready = 1'b1;

  int n_checks = 0;
  int n_errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference model of the register file
  logic [31:0] m_a, m_b, m_sum;
  logic        m_cy, m_done, m_seen_s, m_seen_c;

  always #2 clk = ~clk;

  axil_adder_regs uut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_a = '0; m_b = '0; m_sum = '0; m_cy = 1'b0;
    m_done = 1'b0; m_seen_s = 1'b0; m_seen_c = 1'b0;
  endtask

  task automatic model_write(input logic [7:0] addr, input logic [31:0] d, input logic [3:0] st);
    logic [32:0] full;
    case (addr[7:2])
      6'd0: for (int k = 0; k < 4; k++) if (st[k]) m_a[k*8 +: 8] = d[k*8 +: 8];
      6'd1: for (int k = 0; k < 4; k++) if (st[k]) m_b[k*8 +: 8] = d[k*8 +: 8];
      6'd2: if (st[0] && d[0]) begin
        full = {1'b0, m_a} + {1'b0, m_b};
        m_sum = full[31:0]; m_cy = full[32];
        m_done = 1'b1; m_seen_s = 1'b0; m_seen_c = 1'b0;
      end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] addr);
    logic [31:0] v;
    case (addr[7:2])
      6'd0: v = m_a;
      6'd1: v = m_b;
      6'd2: v = {30'd0, m_done, 1'b0};
      6'd3: begin v = m_sum; m_seen_s = 1'b1; end
      6'd4: begin v = {31'd0, m_cy}; m_seen_c = 1'b1; end
      default: v = '0;
    endcase
    if (m_seen_s && m_seen_c) m_done = 1'b0;
    return v;
  endfunction

  // mode 0: address and data together, 1: address first, 2: data first
  task automatic wr(input logic [7:0] addr, input logic [31:0] d, input logic [3:0] st,
                    input int mode, input int bhold, input string req);
    bit aw_done = 0, w_done = 0, aw_acc, w_acc, fin = 0;
    int aw_wait = (mode == 2) ? 2 : 0;
    int w_wait  = (mode == 1) ? 2 : 0;
    s_awaddr = addr; s_wdata = d; s_wstrb = st;
    if (bhold > 0) s_bready = 1'b0;
    while (!(aw_done && w_done)) begin
      s_awvalid = !aw_done && (aw_wait == 0);
      s_wvalid  = !w_done && (w_wait == 0);
      @(negedge clk);
      aw_acc = s_awvalid && s_awready;
      w_acc  = s_wvalid && s_wready;
      @(posedge clk); #1;
      if (aw_acc) aw_done = 1;
      if (w_acc) w_done = 1;
      if (aw_wait > 0) aw_wait--;
      if (w_wait > 0) w_wait--;
    end
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    if (bhold > 0) begin
      do @(negedge clk); while (!s_bvalid);
      for (int i = 0; i < bhold; i++) begin
        @(negedge clk);
        check({req, " bvalid held (R8)"}, {31'd0, s_bvalid}, 32'd1);
      end
      @(posedge clk); #1;
      s_bready = 1'b1;
    end
    while (!fin) begin
      @(negedge clk);
      if (s_bvalid && s_bready) begin
        check({req, " bresp OKAY (R8)"}, {30'd0, s_bresp}, 32'd0);
        model_write(addr, d, st);
        fin = 1;
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic rd(input logic [7:0] addr, input int rhold, input string req);
    bit acc = 0, fin = 0;
    logic [31:0] e;
    s_araddr = addr; s_arvalid = 1'b1;
    if (rhold > 0) s_rready = 1'b0;
    while (!acc) begin
      @(negedge clk);
      if (s_arready) begin
        e = model_read(addr);
        exp_q.push_back(e);
        tag_q.push_back(req);
        acc = 1;
      end
      @(posedge clk); #1;
    end
    s_arvalid = 1'b0;
    if (rhold > 0) begin
      for (int i = 0; i < rhold; i++) begin
        @(negedge clk);
        check({req, " rvalid held (R9)"}, {31'd0, s_rvalid}, 32'd1);
        check({req, " rdata stable (R9)"}, s_rdata, e);
      end
      @(posedge clk); #1;
      s_rready = 1'b1;
    end
    while (!fin) begin
      @(negedge clk);
      if (s_rvalid && s_rready) fin = 1;
      @(posedge clk); #1;
    end
  endtask

  // monitor: pops the expected read data as each response is taken
  always @(negedge clk) begin
    if (rst_n && s_rvalid && s_rready) begin
      if (exp_q.size() == 0) begin
        check("unexpected read response (R9)", s_rdata, 32'hDEAD_BEEF);
      end else begin
        string t;
        logic [31:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, s_rdata, e);
        check({t, " rresp OKAY (R9)"}, {30'd0, s_rresp}, 32'd0);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    model_reset();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    do_reset();

    // R1: idle outputs and zero contents after reset
    @(negedge clk);
    check("R1 bvalid after reset", {31'd0, s_bvalid}, 32'd0);
    check("R1 rvalid after reset", {31'd0, s_rvalid}, 32'd0);
    check("R1 awready after reset", {31'd0, s_awready}, 32'd1);
    check("R1 arready after reset", {31'd0, s_arready}, 32'd1);
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++) rd(8'(i * 4), 0, "R1 reset value");

    // R2: operands read back, strobes and all three channel orders (R8)
    wr(8'h00, 32'h1234_5678, 4'hF, 0, 0, "R2 opa");
    wr(8'h04, 32'h0BAD_F00D, 4'hF, 1, 0, "R2 opb aw first");
    rd(8'h00, 0, "R2 opa readback");
    rd(8'h04, 0, "R2 opb readback");
    wr(8'h00, 32'hAABB_CCDD, 4'b0101, 2, 0, "R2 opa strobe w first");
    rd(8'h00, 0, "R2 opa partial strobe");

    // R3/R4: launch, results, go bit reads 0
    wr(8'h08, 32'h1, 4'h1, 0, 0, "R3 launch");
    rd(8'h08, 0, "R3 go reads 0, R5 done set");
    rd(8'h0C, 0, "R4 sum");
    rd(8'h08, 0, "R5 done kept after sum only");
    rd(8'h0C, 0, "R5 sum again");
    rd(8'h08, 0, "R5 done kept after sum twice");
    rd(8'h10, 0, "R4 carry");
    rd(8'h08, 0, "R5 done cleared after both");

    // R4: full-scale addition, reverse read order for R5
    wr(8'h00, 32'hFFFF_FFFF, 4'hF, 0, 0, "R4 opa max");
    wr(8'h04, 32'hFFFF_FFFF, 4'hF, 2, 0, "R4 opb max");
    wr(8'h08, 32'h1, 4'h1, 1, 0, "R4 launch max");
    rd(8'h10, 0, "R4 carry max");
    rd(8'h08, 0, "R5 done kept after carry only");
    rd(8'h0C, 0, "R4 sum max");
    rd(8'h08, 0, "R5 done cleared reverse order");

    // R3: launch without strobe or with bit0 clear does nothing; new launch overwrites
    wr(8'h04, 32'h0000_0001, 4'hF, 0, 0, "R3 opb one");
    wr(8'h08, 32'h1, 4'h0, 0, 0, "R3 launch no strobe");
    wr(8'h08, 32'h2, 4'hF, 0, 0, "R3 bit0 clear, R6 done write");
    rd(8'h08, 0, "R6 done not writable");
    rd(8'h0C, 0, "R3 sum unchanged without launch");
    wr(8'h08, 32'h1, 4'h1, 0, 0, "R3 relaunch");
    rd(8'h0C, 0, "R3 overwritten sum");
    rd(8'h10, 0, "R3 overwritten carry");

    // R6: result registers ignore writes
    wr(8'h0C, 32'h5555_5555, 4'hF, 0, 0, "R6 sum write");
    wr(8'h10, 32'hFFFF_FFFF, 4'hF, 0, 0, "R6 carry write");
    rd(8'h0C, 0, "R6 sum unchanged");
    rd(8'h10, 0, "R6 carry unchanged");

    // R7: misaligned and out-of-range accesses
    wr(8'h07, 32'h0000_00C3, 4'hF, 0, 0, "R7 misaligned opb");
    rd(8'h05, 0, "R7 misaligned opb read");
    rd(8'h0E, 0, "R7 misaligned sum read");
    wr(8'h14, 32'hFFFF_FFFF, 4'hF, 0, 0, "R7 out of range write");
    wr(8'hFC, 32'hFFFF_FFFF, 4'hF, 2, 0, "R7 far out of range write");
    rd(8'h14, 0, "R7 out of range read");
    rd(8'hFC, 0, "R7 far out of range read");
    for (int i = 0; i < 5; i++) rd(8'(i * 4), 0, "R7 map intact");

    // R8/R9: response held while the master stalls
    wr(8'h00, 32'h0F0F_0F0F, 4'hF, 0, 3, "R8 stalled bresp");
    rd(8'h00, 3, "R9 stalled rdata");

    // R10: write and read offered together; write goes first
    fork
      wr(8'h00, 32'hCAFE_0001, 4'hF, 0, 0, "R10 concurrent write");
      rd(8'h00, 0, "R10 read after write");
    join

    // back-to-back alternating traffic
    for (int i = 0; i < 6; i++) begin
      wr(8'((i % 2) * 4), 32'h100 * i + 32'h7, 4'hF, i % 3, 0, "R2 alternating write");
      rd(8'(((i + 1) % 2) * 4), 0, "R2 alternating read");
    end
    wr(8'h08, 32'h1, 4'h1, 0, 0, "R3 alternating launch");
    rd(8'h0C, 0, "R4 alternating sum");

    // R11: reset during a pending write, after a computation
    s_awaddr = 8'h00; s_awvalid = 1'b1; s_wvalid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b0;
    s_awvalid = 1'b0;
    @(negedge clk);
    check("R11 bvalid in reset", {31'd0, s_bvalid}, 32'd0);
    check("R11 rvalid in reset", {31'd0, s_rvalid}, 32'd0);
    do_reset();
    for (int i = 0; i < 5; i++) rd(8'(i * 4), 0, "R11 cleared by reset");
    wr(8'h04, 32'h0000_0042, 4'hF, 1, 0, "R11 write after reset");
    rd(8'h04, 0, "R11 read after reset");

    repeat (4) @(posedge clk);
    check("R9 no outstanding reads", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule